// File: doc/BRIEF.md
# Display Blink and Scan Timing Controller

This block keeps the configuration byte of a multiplexed display controller and runs the two timers that depend on it. A free-running blink timer counts clock-enable ticks and toggles a blink phase. A scan counter steps through the digit positions, one position per tick. The highest position depends on the selected display mode: a wide layout of 96 digit positions without annunciators, or a narrow layout of 48 positions with annunciator segments.

A host interface writes the configuration byte through a one-cycle write strobe. Three bits of the byte act as commands instead of stored settings. The sync bit restarts the blink timer and the scan sequence together, so several controllers written close together blink in step. The clear bit sends a one-cycle request to the display memory to zero its segment and annunciator data. The mode bit selects the layout. A read strobe captures a readback byte. In that byte the top bit is the live blink phase at the moment of the read, not a stored value.

Top module: `dispTiming`

## Requirements
- R1: While `rstN` is low and directly after it, `blinkPhase`, `scanIdx`, `clrReq`, `narrowMode` and `cfgRdData` are all 0.
- R2: `blinkPhase` toggles on every BLINK_TICKS-th cycle with `tickEn` high, counted from reset or from the last sync. It holds in cycles without `tickEn`. The default BLINK_TICKS is 256.
- R3: In wide mode (`narrowMode`=0), `scanIdx` advances by one on each cycle with `tickEn` high and wraps from 95 to 0.
- R4: `narrowMode` takes bit 6 of each written byte, from the cycle after the write. In narrow mode `scanIdx` wraps from 47 to 0.
- R5: A write whose bit 6 differs from the current `narrowMode` sets `scanIdx` to 0 in the next cycle. A write that keeps the mode leaves the scan running.
- R6: A write with bit 4 set sets `blinkPhase` to 0 and `scanIdx` to 0 in the next cycle, even if `tickEn` is high in that cycle. The next phase toggle comes after a full BLINK_TICKS ticks.
- R7: A write with bit 5 set makes `clrReq` high for exactly the next cycle. In all other cycles `clrReq` is low.
- R8: In the cycle after `cfgRdEn`, `cfgRdData` holds: bit 7 = `blinkPhase` in the read cycle, bit 6 = current mode, bits 5:4 = 0, bits 3:0 = the low nibble of the last write. If a read and a write fall in the same cycle, the read returns the values from before the write. Between reads `cfgRdData` holds its value.
- R9: Bit 7 of a written byte has no effect: `blinkPhase` does not change because of it.
- R10: A write with bits 4 and 5 clear and an unchanged mode does not disturb the timers: a tick in the same cycle still advances `scanIdx` and the blink count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Configuration byte to write |
| cfgRdEn | input | 1 | Configuration read strobe |
| tickEn | input | 1 | Timer clock-enable tick |
| blinkPhase | output | 1 | Current blink phase |
| scanIdx | output | 7 | Current multiplex digit position |
| clrReq | output | 1 | One-cycle request to clear display memory |
| narrowMode | output | 1 | Mode flag: 1 = 48 positions with annunciators |
| cfgRdData | output | 8 | Readback byte captured on the last read |

## Verification
The bench drives a continuous tick stream so that the blink phase passes its 256-tick boundary. Comparing this with gapped ticks shows whether the timer counts ticks or clock cycles. Scan wrap is exercised in both modes. Mode-changing writes are compared with mode-keeping writes, which separates a restart caused by the mode change from a restart caused by any write. Sync writes land in cycles that also carry a tick, which checks the precedence. Reads taken on both blink phases, and reads that share a cycle with a write, confirm that the top readback bit is live and the other bits come from before the write. A long random mix of writes, reads and ticks is compared with the reference model on every clock.

// File: rtl/dispTimingPkg.sv
package dispTimingPkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic restartBlink;  // sync write: blink count and phase to zero
    logic restartScan;   // sync or mode change: scan back to position 0
    logic advance;       // one timer tick this cycle
    logic wideSel;       // current layout is the wide one
    logic capture;       // latch readback byte
  } tmgStrobes_t;

  localparam int unsigned SYNC_BIT  = 4;
  localparam int unsigned CLEAR_BIT = 5;
  localparam int unsigned MODE_BIT  = 6;

endpackage

// File: rtl/dispTimingCtl.sv
module dispTimingCtl
  import dispTimingPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [7:0]  cfgWrData,
  input  logic        cfgRdEn,
  input  logic        tickEn,
  output tmgStrobes_t strb,
  output logic [3:0]  lowBits,
  output logic        modeQ,
  output logic        clrReq
);

  logic syncHit;
  logic modeFlip;
  logic unusedTopBit;

  // The top bit of a written byte carries no setting
  assign unusedTopBit = cfgWrData[7];

  assign syncHit  = cfgWrEn & cfgWrData[SYNC_BIT];
  assign modeFlip = cfgWrEn & (cfgWrData[MODE_BIT] != modeQ);

  always_comb begin
    strb.restartBlink = syncHit;
    strb.restartScan  = syncHit | modeFlip;
    strb.advance      = tickEn;
    strb.wideSel      = ~modeQ;
    strb.capture      = cfgRdEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowBits <= 4'h0;
      modeQ   <= 1'b0;
      clrReq  <= 1'b0;
    end else begin
      clrReq <= cfgWrEn & cfgWrData[CLEAR_BIT];
      if (cfgWrEn) begin
        lowBits <= cfgWrData[3:0];
        modeQ   <= cfgWrData[MODE_BIT];
      end
    end
  end

endmodule

// File: rtl/dispTimingDp.sv
module dispTimingDp
  import dispTimingPkg::*;
#(
  parameter int unsigned BLINK_TICKS   = 256,
  parameter int unsigned WIDE_DIGITS   = 96,
  parameter int unsigned NARROW_DIGITS = 48,
  localparam int unsigned SCAN_W = $clog2(WIDE_DIGITS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  tmgStrobes_t       strb,
  input  logic [3:0]        lowBits,
  input  logic              modeQ,
  output logic              blinkPhase,
  output logic [SCAN_W-1:0] scanIdx,
  output logic [7:0]        cfgRdData
);

  localparam logic [SCAN_W-1:0] WIDE_LAST   = SCAN_W'(WIDE_DIGITS - 1);
  localparam logic [SCAN_W-1:0] NARROW_LAST = SCAN_W'(NARROW_DIGITS - 1);

  logic [SCAN_W-1:0] scanLast;
  logic              blinkWrap;

  // Blink timer: a parameter selects a counted or a direct variant
  generate
    if (BLINK_TICKS > 1) begin : gCounted
      localparam int unsigned BLINK_W = $clog2(BLINK_TICKS);
      localparam logic [BLINK_W-1:0] BLINK_LAST = BLINK_W'(BLINK_TICKS - 1);
      logic [BLINK_W-1:0] blinkCnt;

      assign blinkWrap = strb.advance && (blinkCnt == BLINK_LAST);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          blinkCnt <= '0;
        end else if (strb.restartBlink) begin
          blinkCnt <= '0;
        end else if (strb.advance) begin
          blinkCnt <= blinkWrap ? '0 : blinkCnt + 1'b1;
        end
      end
    end else begin : gDirect
      assign blinkWrap = strb.advance;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blinkPhase <= 1'b0;
    end else if (strb.restartBlink) begin
      blinkPhase <= 1'b0;
    end else if (blinkWrap) begin
      blinkPhase <= ~blinkPhase;
    end
  end

  // Multiplex scan counter
  assign scanLast = strb.wideSel ? WIDE_LAST : NARROW_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanIdx <= '0;
    end else if (strb.restartScan) begin
      scanIdx <= '0;
    end else if (strb.advance) begin
      scanIdx <= (scanIdx >= scanLast) ? '0 : scanIdx + 1'b1;
    end
  end

  // Readback: live phase on top, command strobes read as zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRdData <= 8'h00;
    end else if (strb.capture) begin
      cfgRdData <= {blinkPhase, modeQ, 2'b00, lowBits};
    end
  end

endmodule

// File: rtl/dispTiming.sv
module dispTiming
  import dispTimingPkg::*;
#(
  parameter int unsigned BLINK_TICKS   = 256,
  parameter int unsigned WIDE_DIGITS   = 96,
  parameter int unsigned NARROW_DIGITS = 48,
  localparam int unsigned SCAN_W = $clog2(WIDE_DIGITS)
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  input  logic              cfgRdEn,
  input  logic              tickEn,
  output logic              blinkPhase,
  output logic [SCAN_W-1:0] scanIdx,
  output logic              clrReq,
  output logic              narrowMode,
  output logic [7:0]        cfgRdData
);

  tmgStrobes_t strb;
  logic [3:0]  lowBits;
  logic        modeQ;

  dispTimingCtl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .cfgRdEn   (cfgRdEn),
    .tickEn    (tickEn),
    .strb      (strb),
    .lowBits   (lowBits),
    .modeQ     (modeQ),
    .clrReq    (clrReq)
  );

  dispTimingDp #(
    .BLINK_TICKS   (BLINK_TICKS),
    .WIDE_DIGITS   (WIDE_DIGITS),
    .NARROW_DIGITS (NARROW_DIGITS)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .lowBits    (lowBits),
    .modeQ      (modeQ),
    .blinkPhase (blinkPhase),
    .scanIdx    (scanIdx),
    .cfgRdData  (cfgRdData)
  );

  assign narrowMode = modeQ;

endmodule

// File: rtl/dispTimingChk.sv
module dispTimingChk #(
  parameter int unsigned WIDE_DIGITS   = 96,
  parameter int unsigned NARROW_DIGITS = 48,
  localparam int unsigned SCAN_W = $clog2(WIDE_DIGITS)
)(
  input logic              clk,
  input logic              rstN,
  input logic              cfgWrEn,
  input logic [7:0]        cfgWrData,
  input logic              cfgRdEn,
  input logic              tickEn,
  input logic              blinkPhase,
  input logic [SCAN_W-1:0] scanIdx,
  input logic              clrReq,
  input logic              narrowMode,
  input logic [7:0]        cfgRdData
);

  localparam logic [SCAN_W-1:0] WIDE_LAST   = SCAN_W'(WIDE_DIGITS - 1);
  localparam logic [SCAN_W-1:0] NARROW_LAST = SCAN_W'(NARROW_DIGITS - 1);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_IDLE: assert (!clrReq && !blinkPhase && scanIdx == '0 && !narrowMode); // R1
    end
  end

  AST_SCAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    scanIdx <= (narrowMode ? NARROW_LAST : WIDE_LAST)); // R4

  AST_SCAN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !cfgWrEn && !narrowMode && scanIdx < WIDE_LAST) |=> scanIdx == $past(scanIdx) + 1'b1); // R3

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !(cfgWrEn && cfgWrData[4])) |=> $stable(blinkPhase)); // R2

  AST_SYNC_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData[4]) |=> (!blinkPhase && scanIdx == '0)); // R6

  AST_MODE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData[6] != narrowMode) |=> scanIdx == '0); // R5

  AST_MODE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> narrowMode == $past(cfgWrData[6])); // R4

  AST_CLR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData[5]) |=> clrReq); // R7

  AST_CLR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgWrEn && cfgWrData[5]) |=> !clrReq); // R7

  AST_READ_LIVE: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdEn |=> (cfgRdData[7] == $past(blinkPhase) && cfgRdData[5:4] == 2'b00)); // R8

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdEn |=> $stable(cfgRdData)); // R8

endmodule

bind dispTiming dispTimingChk #(
  .WIDE_DIGITS   (WIDE_DIGITS),
  .NARROW_DIGITS (NARROW_DIGITS)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWrEn    (cfgWrEn),
  .cfgWrData  (cfgWrData),
  .cfgRdEn    (cfgRdEn),
  .tickEn     (tickEn),
  .blinkPhase (blinkPhase),
  .scanIdx    (scanIdx),
  .clrReq     (clrReq),
  .narrowMode (narrowMode),
  .cfgRdData  (cfgRdData)
);

// File: tb/sim_dispTiming.sv
`timescale 1ns/1ps
module sim_dispTiming;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic       cfgRdEn = 1'b0;
  logic       tickEn = 1'b0;
  logic       blinkPhase;
  logic [6:0] scanIdx;
  logic       clrReq;
  logic       narrowMode;
  logic [7:0] cfgRdData;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  dispTiming u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdEn(cfgRdEn), .tickEn(tickEn), .blinkPhase(blinkPhase),
    .scanIdx(scanIdx), .clrReq(clrReq), .narrowMode(narrowMode),
    .cfgRdData(cfgRdData)
  );

  // Behavioural reference model
  int mCnt, mPhase, mScan, mMode, mLow, mClr, mRd;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPhase = 0; mScan = 0; mMode = 0; mLow = 0; mClr = 0; mRd = 0;
    end else begin
      int oldMode;
      int lim;
      oldMode = mMode;
      lim = oldMode ? 48 : 96;
      if (cfgRdEn) mRd = mPhase * 128 + oldMode * 64 + mLow;
      mClr = (cfgWrEn && cfgWrData[5]) ? 1 : 0;
      if (cfgWrEn && cfgWrData[4]) begin
        mCnt = 0; mPhase = 0;
      end else if (tickEn) begin
        mCnt = mCnt + 1;
        if (mCnt == 256) begin mCnt = 0; mPhase = 1 - mPhase; end
      end
      if (cfgWrEn && (cfgWrData[4] || int'(cfgWrData[6]) != oldMode)) mScan = 0;
      else if (tickEn) mScan = (mScan + 1) % lim;
      if (cfgWrEn) begin
        mMode = int'(cfgWrData[6]);
        mLow = int'(cfgWrData[3:0]);
      end
    end
  end

  task automatic chk(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic compareAll();
    chk("blinkPhase", int'(blinkPhase), mPhase);
    chk("scanIdx", int'(scanIdx), mScan);
    chk("clrReq", int'(clrReq), mClr);
    chk("narrowMode", int'(narrowMode), mMode);
    chk("cfgRdData", int'(cfgRdData), mRd);
  endtask

  // One cycle of stimulus; compared at the following falling edge
  task automatic cyc(input bit wr, input logic [7:0] d, input bit rd, input bit tk);
    cfgWrEn = wr; cfgWrData = d; cfgRdEn = rd; tickEn = tk;
    @(negedge clk);
    compareAll();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 8'h00, 1'b0, 1'b1);
  endtask

  initial begin
    #(5.0 * 60000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tag = "R1";
    chk("reset blinkPhase", int'(blinkPhase), 0);
    chk("reset scanIdx", int'(scanIdx), 0);
    chk("reset clrReq", int'(clrReq), 0);
    chk("reset narrowMode", int'(narrowMode), 0);
    chk("reset cfgRdData", int'(cfgRdData), 0);
    rstN = 1'b1;
    cyc(1'b0, 8'h00, 1'b0, 1'b0);

    tag = "R3"; ticks(100);                       // wide wrap at 95
    tag = "R2"; ticks(200);                       // phase toggle at 256
    chk("phase after 300 ticks", int'(blinkPhase), 1);
    repeat (10) cyc(1'b0, 8'h00, 1'b0, 1'b0);     // no ticks: hold
    tag = "R8"; cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("live phase in readback", int'(cfgRdData[7]), 1);

    tag = "R5"; cyc(1'b1, 8'h4A, 1'b0, 1'b1);     // to narrow mode
    chk("scan restart on mode change", int'(scanIdx), 0);
    tag = "R4"; ticks(60);                        // narrow wrap at 47
    tag = "R10"; cyc(1'b1, 8'h43, 1'b0, 1'b1);    // same mode, plain write
    tag = "R8"; cyc(1'b0, 8'h00, 1'b1, 1'b0);
    chk("readback nibble and mode", int'(cfgRdData[6:0]), 8'h43);

    tag = "R6"; ticks(20);
    cyc(1'b1, 8'h50, 1'b0, 1'b1);                 // sync with tick
    chk("sync scan", int'(scanIdx), 0);
    chk("sync phase", int'(blinkPhase), 0);
    tag = "R2"; ticks(256);

    tag = "R7"; cyc(1'b1, 8'h60, 1'b0, 1'b0);
    chk("clear pulse", int'(clrReq), 1);
    cyc(1'b0, 8'h00, 1'b0, 1'b0);
    chk("clear ends", int'(clrReq), 0);

    tag = "R9"; cyc(1'b1, 8'h80, 1'b1, 1'b1);     // top bit ignored, wide mode
    cyc(1'b1, 8'hB5, 1'b1, 1'b0);                 // write+read same cycle, sync
    cyc(1'b0, 8'h00, 1'b1, 1'b0);

    tag = "R8";
    for (int i = 0; i < 3000; i++) begin
      bit wr, rd, tk;
      wr = ($urandom_range(0, 15) == 0);
      rd = ($urandom_range(0, 7) == 0);
      tk = ($urandom_range(0, 9) < 7);
      cyc(wr, 8'($urandom_range(0, 255)), rd, tk);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule